// File: doc/BRIEF.md
# Serial configuration readout controller

This block is the read side of a serial configuration store that feeds a programmable-logic device one bit per clock. A bit array of parameterised depth is read out through an offset counter. An active-low reset/output-enable input and an active-low chip enable decide when the counter runs and when the data pin is driven. A cascade-enable output tells the next store in a chain that this one has finished, so that the next store can take the shared data line.

The array holds four equal bitstreams. When the page-enable input is high while reset/output-enable is low, the two page-select inputs choose which quarter is read. When page-enable is low at that time, the whole array is read from address zero. The tri-state of the data pin is shown as a separate `data_oe` flag next to `data_out`.

All inputs are sampled on the rising clock edge and all outputs are registered, so every reaction appears after the edge that sees the input. The array content is fixed when the block is built and is computed from an address mask.

Top module: `cfgmem_reader`

## Requirements
- R1: An edge that sees `rst_oe_n` low clears the offset counter to zero. After that edge `data_oe` is 0 and `ceo_n` is 1, whatever the level of `ce_n`, even if the block had finished.
- R2: An edge that sees `rst_oe_n` high and `ce_n` high sets `data_oe` to 0 and holds the counter. When `ce_n` returns low, the bit that was last shown is shown again.
- R3: The first enabling edge after a reset (`rst_oe_n` high and `ce_n` low) drives the bit at the start of the selected range without advancing. Each later enabling edge advances the read address by exactly one.
- R4: The bit stored at address `a` is the XOR reduction of (`a` AND `MASK`). With the default `DEPTH`=1024, `MASK` is 0x3A5.
- R5: The last bit of the range is shown for one cycle. The next enabling edge sets `ceo_n` to 0 and `data_oe` to 0. `ceo_n` is never 0 while `data_oe` is 1.
- R6: If `page_en` is 1 while `rst_oe_n` is low, the read covers `DEPTH/4` bits starting at `page_sel*DEPTH/4`, where `page_sel` is read as an unsigned 2-bit number.
- R7: If `page_en` is 0 while `rst_oe_n` is low, the read covers all `DEPTH` bits starting at address 0.
- R8: `page_en` and `page_sel` are captured only on edges that see `rst_oe_n` low. Changes while `rst_oe_n` is high have no effect on the range being read.
- R9: The synchronous `rst` input puts the block in its power-up state: `data_oe` 0, `ceo_n` 1, counter 0, whole-array mode.
- R10: Once `ceo_n` is 0, toggling `ce_n` has no effect. `data_oe` stays 0 and `ceo_n` stays 0 until `rst_oe_n` goes low or `rst` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; every register changes on its rising edge |
| rst | input | 1 | Synchronous active-high power-up reset |
| rst_oe_n | input | 1 | Active-low reset of the read; high enables output |
| ce_n | input | 1 | Active-low chip enable |
| page_en | input | 1 | Selects page mode when captured |
| page_sel | input | 2 | Page number, captured while `rst_oe_n` is low |
| data_out | output | 1 | Serial data bit; meaningful only while `data_oe` is 1 |
| data_oe | output | 1 | High when the data line is driven |
| ceo_n | output | 1 | Active-low cascade enable; low once the range is finished |

## Verification
The readout is tried with a full-array read straight after power-up and then with a read of each of the four pages. The pages differ in the top address bits of the mask pattern, so a wrong base address or a wrong range length shows up as a data mismatch or as a `ceo_n` that falls at the wrong time. One read is paused in the middle with `ce_n`. This tells a counter that holds apart from one that skips or repeats a bit on resume. A reset/output-enable pulse during a read and another after the end, each with chip enable high and then low, show whether reset takes priority over chip enable. Page inputs are changed after capture and `ce_n` is toggled after the end, to show that both are ignored.

// File: rtl/cfgrd_pkg.sv
package cfgrd_pkg;

  // Captured page setting: whole-array mode or one of four quarters
  typedef struct packed {
    logic       whole;
    logic [1:0] sel;
  } page_t;

  // Stored bit at an address: XOR reduction of the masked address
  function automatic logic pat_bit(input int unsigned addr, input int unsigned mask);
    return ^(addr & mask);
  endfunction

endpackage

// File: rtl/cfgrd_page_latch.sv
module cfgrd_page_latch
  import cfgrd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       page_en,
  input  logic [1:0] page_sel,
  output page_t      pg_q,
  output page_t      pg_d
);

  always_comb begin
    pg_d = pg_q;
    if (load) begin
      pg_d.whole = ~page_en;
      pg_d.sel   = page_en ? page_sel : 2'b00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pg_q.whole <= 1'b1;
      pg_q.sel   <= 2'b00;
    end else begin
      pg_q <= pg_d;
    end
  end

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!load) |=> (pg_q == $past(pg_q))) else $error("page setting moved outside capture"); // R8

endmodule

// File: rtl/cfgrd_addr_ctr.sv
module cfgrd_addr_ctr #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [ADDR_W-1:0] last_off,
  output logic [ADDR_W-1:0] off_q,
  output logic [ADDR_W-1:0] off_d,
  output logic              live_q,
  output logic              done_q
);

  logic live_d;
  logic done_d;
  logic step;

  // An edge consumes the shown bit only if it was driven and still enabled
  assign step = en && !done_q && live_q;

  always_comb begin
    off_d  = off_q;
    live_d = live_q;
    done_d = done_q;
    if (clr) begin
      off_d  = '0;
      live_d = 1'b0;
      done_d = 1'b0;
    end else if (en && !done_q) begin
      if (!live_q) begin
        live_d = 1'b1;
      end else if (off_q == last_off) begin
        done_d = 1'b1;
        live_d = 1'b0;
      end else begin
        off_d = off_q + ADDR_W'(1);
      end
    end else begin
      live_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      off_q  <= '0;
      live_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      off_q  <= off_d;
      live_q <= live_d;
      done_q <= done_d;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !step) |=> (off_q == $past(off_q))) else $error("offset moved while idle"); // R2

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clr && step && off_q != last_off) |=> (off_q == $past(off_q) + ADDR_W'(1))) else $error("offset step wrong"); // R3

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done_q && !clr) |=> done_q) else $error("done dropped without clear"); // R10

endmodule

// File: rtl/cfgrd_bit_rom.sv
module cfgrd_bit_rom
  import cfgrd_pkg::*;
#(
  parameter int          DEPTH  = 1024,
  parameter int unsigned MASK   = 32'h3A5,
  localparam int         ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_bit
);

  logic mem [0:DEPTH-1];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = pat_bit(i, MASK);
    end
  end

  // Synchronous read port so the array maps onto block memory
  always_ff @(posedge clk) begin
    rd_bit <= mem[rd_addr];
  end

endmodule

// File: rtl/cfgmem_reader.sv
module cfgmem_reader
  import cfgrd_pkg::*;
#(
  parameter int          DEPTH = 1024,
  parameter int unsigned MASK  = 32'h3A5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rst_oe_n,
  input  logic       ce_n,
  input  logic       page_en,
  input  logic [1:0] page_sel,
  output logic       data_out,
  output logic       data_oe,
  output logic       ceo_n
);

  localparam int ADDR_W     = $clog2(DEPTH);
  localparam int PAGE_W     = ADDR_W - 2;
  localparam int PAGE_DEPTH = DEPTH / 4;

  page_t             pg_q;
  page_t             pg_d;
  logic [ADDR_W-1:0] off_q;
  logic [ADDR_W-1:0] off_d;
  logic [ADDR_W-1:0] last_off;
  logic [ADDR_W-1:0] base_d;
  logic [ADDR_W-1:0] rd_addr;
  logic              live_q;
  logic              done_q;
  logic              clr;
  logic              en;

  assign clr = ~rst_oe_n;
  assign en  = rst_oe_n & ~ce_n;

  cfgrd_page_latch u_page (
    .clk      (clk),
    .rst      (rst),
    .load     (clr),
    .page_en  (page_en),
    .page_sel (page_sel),
    .pg_q     (pg_q),
    .pg_d     (pg_d)
  );

  assign last_off = pg_q.whole ? ADDR_W'(DEPTH - 1) : ADDR_W'(PAGE_DEPTH - 1);

  cfgrd_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .en       (en),
    .last_off (last_off),
    .off_q    (off_q),
    .off_d    (off_d),
    .live_q   (live_q),
    .done_q   (done_q)
  );

  // Read ahead: the array is addressed with next-state values so its
  // registered output lines up with the counter
  assign base_d  = pg_d.whole ? '0 : {pg_d.sel, {PAGE_W{1'b0}}};
  assign rd_addr = base_d + off_d;

  cfgrd_bit_rom #(.DEPTH(DEPTH), .MASK(MASK)) u_rom (
    .clk     (clk),
    .rd_addr (rd_addr),
    .rd_bit  (data_out)
  );

  assign data_oe = live_q;
  assign ceo_n   = ~done_q;

  AST_RSTOE_WINS: assert property (@(posedge clk) disable iff (rst)
    (!rst_oe_n) |=> (!data_oe && ceo_n)) else $error("reset/oe did not release line"); // R1

  AST_CE_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ce_n) |=> (!data_oe)) else $error("line driven with chip enable high"); // R2

  AST_CEO_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!ceo_n) |-> (!data_oe)) else $error("line driven after cascade hand-off"); // R5

  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (!pg_q.whole) |-> (off_q < ADDR_W'(PAGE_DEPTH))) else $error("offset left page"); // R6

endmodule

// File: tb/cfgmem_reader_test.sv
module cfgmem_reader_test;

  localparam int          DEPTH = 1024;
  localparam int unsigned MASK  = 32'h3A5;
  localparam int          PD    = DEPTH / 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_oe_n = 1'b1;
  logic       ce_n = 1'b1;
  logic       page_en = 1'b0;
  logic [1:0] page_sel = 2'b00;
  logic       data_out;
  logic       data_oe;
  logic       ceo_n;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cfgmem_reader #(.DEPTH(DEPTH), .MASK(MASK)) uut (
    .clk      (clk),
    .rst      (rst),
    .rst_oe_n (rst_oe_n),
    .ce_n     (ce_n),
    .page_en  (page_en),
    .page_sel (page_sel),
    .data_out (data_out),
    .data_oe  (data_oe),
    .ceo_n    (ceo_n)
  );

  // R4: expected stored bit
  function automatic logic exp_bit(input int a);
    return ^(a & MASK);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Reads n bits from base; expects enable already applied
  task automatic read_range(input int base, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step();
      chk(data_oe, 1'b1, {tag, " R3 data_oe during read"});
      chk(data_out, exp_bit(base + i), {tag, " R4 data bit"});
      chk(ceo_n, 1'b1, {tag, " R5 ceo_n high during read"});
    end
    step();
    chk(data_oe, 1'b0, {tag, " R5 data_oe after last bit"});
    chk(ceo_n, 1'b0, {tag, " R5 ceo_n after last bit"});
  endtask

  // Pulse reset/oe with a page setting, then scramble the page inputs (R8)
  task automatic pulse(input logic pe, input logic [1:0] sel, input logic ce_during);
    rst_oe_n = 1'b0;
    ce_n     = ce_during;
    page_en  = pe;
    page_sel = sel;
    step();
    chk(data_oe, 1'b0, "R1 data_oe during reset/oe");
    chk(ceo_n, 1'b1, "R1 ceo_n during reset/oe");
    rst_oe_n = 1'b1;
    page_en  = ~pe;
    page_sel = ~sel;
  endtask

  task automatic t_power_up();
    rst = 1'b1;
    ce_n = 1'b0;
    step();
    step();
    chk(data_oe, 1'b0, "R9 data_oe in reset");
    chk(ceo_n, 1'b1, "R9 ceo_n in reset");
    rst = 1'b0;
    page_en = 1'b1;
    page_sel = 2'b11;
    read_range(0, DEPTH, "R9 R7 power-up whole array");
  endtask

  task automatic t_pages();
    for (int p = 0; p < 4; p++) begin
      pulse(1'b1, 2'(p), 1'b1);
      ce_n = 1'b0;
      read_range(p * PD, PD, "R6 R8 page read");
    end
  endtask

  task automatic t_whole_after_pulse();
    pulse(1'b0, 2'b10, 1'b0);
    read_range(0, DEPTH, "R7 whole array via page_en low");
  endtask

  task automatic t_done_sticky();
    for (int i = 0; i < 6; i++) begin
      ce_n = i[0];
      step();
      chk(data_oe, 1'b0, "R10 data_oe stays low after end");
      chk(ceo_n, 1'b0, "R10 ceo_n stays low after end");
    end
    ce_n = 1'b1;
    pulse(1'b1, 2'b01, 1'b1);
    chk(ceo_n, 1'b1, "R1 ceo_n cleared after end");
  endtask

  task automatic t_pause();
    pulse(1'b1, 2'b10, 1'b1);
    ce_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk(data_out, exp_bit(2 * PD + i), "R3 pre-pause bit");
    end
    ce_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(data_oe, 1'b0, "R2 data_oe low while paused");
      chk(ceo_n, 1'b1, "R2 ceo_n high while paused");
    end
    ce_n = 1'b0;
    step();
    chk(data_oe, 1'b1, "R2 data_oe on resume");
    chk(data_out, exp_bit(2 * PD + 4), "R2 resume re-shows last bit");
    step();
    chk(data_out, exp_bit(2 * PD + 5), "R3 advance after resume");
  endtask

  task automatic t_priority();
    // Mid-read reset/oe with ce_n low: reset wins
    pulse(1'b1, 2'b01, 1'b0);
    ce_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(data_oe, 1'b0, "R2 ce_n high after reset pulse");
    end
    ce_n = 1'b0;
    step();
    chk(data_out, exp_bit(PD), "R1 counter cleared to page start");
    step();
    chk(data_out, exp_bit(PD + 1), "R3 second bit after clear");
  endtask

  initial begin
    t_power_up();
    t_pages();
    t_done_sticky();
    t_pause();
    t_priority();
    t_whole_after_pulse();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule